// File: doc/BRIEF.md
# Second-Operand Shifter Stage

This block forms the second operand of an arithmetic/logic unit, together with the carry that the shifter hands to the flag logic. It accepts one operation per handshake. Each operation carries a register word, the incoming carry flag and the instruction fields, and the block decodes those fields itself. There are three operand sources. The first shifts the register word by a 5-bit amount taken from the instruction. The second shifts it by the low byte of a second register word. The third takes an 8-bit constant and rotates it right by twice a 4-bit field. Reading the register file is left to the caller.

The shifting logic is combinational. A single output register holds the result. The input side takes a new operation only when that register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. Once `out_valid` is high, the result and its carry stay frozen until `out_ready` is seen high at a clock edge. This back-pressure can pass through the stage in one cycle. The block adds no extra buffering.

Top module: `opshift_stage`

## Requirements
- R1: After reset `out_valid` is 0. An operation accepted at an edge (`in_valid && in_ready`) appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, both `out_operand` and `out_carry` keep their values.
- R2: The operand source is selected by `in_src`: 0 = immediate shift amount, 1 = register shift amount, 2 = rotated constant, 3 = pass-through. `in_kind` gives the shift type: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For an effective amount n with 1 ≤ n ≤ 31, the carry is the last bit shifted out (left shifts: bit 32−n; right shifts and rotates: bit n−1).
- R3: In immediate mode, a logical left shift with amount field 0 returns the value unchanged and passes the incoming carry through.
- R4: In immediate mode, an amount field of 0 with a logical or arithmetic right shift means a shift by 32. Logical right gives 0. Arithmetic right gives every bit equal to bit 31. In both cases the carry is bit 31.
- R5: In immediate mode, rotate right with amount field 0 is a one-bit rotate through carry. The result is {incoming carry, value[31:1]} and the carry is value[0].
- R6: In register mode, only bits 7:0 of `in_amt_word` count. An effective amount of 0 returns the value and the incoming carry unchanged.
- R7: In register mode, a logical left or right shift by exactly 32 gives 0. The carry is bit 0 for a left shift and bit 31 for a right shift. An amount above 32 gives 0 with carry 0.
- R8: In register mode, an arithmetic right shift by 32 or more fills every bit with bit 31 and sets the carry to bit 31.
- R9: In register mode, a rotate by a nonzero amount is a rotate by the amount modulo 32. If that remainder is 0, the value is unchanged and the carry is bit 31.
- R10: In rotated-constant mode, the result is the zero-extended `in_const` rotated right by 2×`in_rot`. The carry is result bit 31 when `in_rot` ≠ 0 and the incoming carry otherwise.
- R11: Source code 3 returns `in_value` and the incoming carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation this cycle |
| in_src | input | 2 | Operand source select |
| in_kind | input | 2 | Shift type |
| in_value | input | 32 | Register word to shift |
| in_imm_amt | input | 5 | Shift amount from the instruction |
| in_amt_word | input | 32 | Register word supplying the amount (low byte used) |
| in_rot | input | 4 | Rotate field for the constant |
| in_const | input | 8 | Constant to rotate |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result held in the stage |
| out_ready | input | 1 | Consumer takes the result |
| out_operand | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
A list of directed operations hits every encoded-zero case, amounts 31, 32, 33 and 255, multiples of 32 for rotates, register words with junk above bit 7, and constants with each rotate value. These operations tell apart the shift-by-32 readings of a zero field, the change to rotate-through-carry, and a carry that was passed through versus one that was produced. Several thousand random operations follow, covering every source and type with both carry values. Values with bit 31 set and cleared separate arithmetic fill from logical zeroing. Throughout the run `out_ready` is dropped at random, so hold behaviour and one-cycle drain-and-refill are checked against an in-order queue of expected results.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_REG  = 2'd1,
    SRC_ROT  = 2'd2,
    SRC_PASS = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } kind_e;

endpackage

// File: rtl/opshift_decode.sv
module opshift_decode
  import opshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int AMT_W   = 8,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic [1:0]        src,
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] value,
  input  logic [SH_W-1:0]   imm_amt,
  input  logic [DATA_W-1:0] amt_word,
  input  logic [ROT_W-1:0]  rot,
  input  logic [IMM_W-1:0]  cval,
  output logic [DATA_W-1:0] op_src,
  output kind_e             op_kind,
  output logic [AMT_W-1:0]  op_amt,
  output logic              op_rrx,
  output logic              op_pass
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [AMT_W-1:0] imm_ext;
  logic [AMT_W-1:0] rot_amt;
  logic [DATA_W-1:0] cval_ext;

  assign imm_ext  = AMT_W'(imm_amt);
  assign rot_amt  = AMT_W'({rot, 1'b0});

  generate
    if (IMM_W < DATA_W) begin : g_zext
      assign cval_ext = {{(DATA_W-IMM_W){1'b0}}, cval};
    end else begin : g_trunc
      assign cval_ext = cval[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    op_src  = value;
    op_kind = kind_e'(kind);
    op_amt  = '0;
    op_rrx  = 1'b0;
    op_pass = 1'b0;
    unique case (src_e'(src))
      SRC_IMM: begin
        op_amt = imm_ext;
        if (imm_amt == '0) begin
          if (kind == KIND_LSR || kind == KIND_ASR) op_amt = FULL;
          if (kind == KIND_ROR) op_rrx = 1'b1;
        end
      end
      SRC_REG: op_amt = amt_word[AMT_W-1:0];
      SRC_ROT: begin
        op_src  = cval_ext;
        op_kind = KIND_ROR;
        op_amt  = rot_amt;
      end
      default: op_pass = 1'b1;
    endcase
  end

endmodule

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] x,
  input  kind_e             kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              pass,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [SH_W-1:0]          sh;
  logic [DATA_W:0]          lsl_w;
  logic [DATA_W:0]          lsr_w;
  logic signed [DATA_W:0]   asr_w;
  logic [2*DATA_W-1:0]      ror_w;

  assign sh    = amt[SH_W-1:0];
  assign lsl_w = {1'b0, x} << sh;
  assign lsr_w = {x, 1'b0} >> sh;
  assign asr_w = $signed({x, 1'b0}) >>> sh;
  assign ror_w = {x, x} >> sh;

  always_comb begin
    res  = x;
    cout = cin;
    if (pass) begin
      res  = x;
      cout = cin;
    end else if (rrx) begin
      res  = {cin, x[DATA_W-1:1]};
      cout = x[0];
    end else if (amt != '0) begin
      unique case (kind)
        KIND_LSL: begin
          if (amt < FULL)       begin res = lsl_w[DATA_W-1:0]; cout = lsl_w[DATA_W]; end
          else if (amt == FULL) begin res = '0; cout = x[0]; end
          else                  begin res = '0; cout = 1'b0; end
        end
        KIND_LSR: begin
          if (amt < FULL)       begin res = lsr_w[DATA_W:1]; cout = lsr_w[0]; end
          else if (amt == FULL) begin res = '0; cout = x[DATA_W-1]; end
          else                  begin res = '0; cout = 1'b0; end
        end
        KIND_ASR: begin
          if (amt < FULL) begin res = asr_w[DATA_W:1]; cout = asr_w[0]; end
          else            begin res = {DATA_W{x[DATA_W-1]}}; cout = x[DATA_W-1]; end
        end
        default: begin
          res  = ror_w[DATA_W-1:0];
          cout = ror_w[DATA_W-1];
        end
      endcase
    end
  end

  always_comb begin
    // R6
    zero_amt_pass_chk: assert (pass || rrx || amt != '0 || (res == x && cout == cin));
    // R7
    lsl_over_chk: assert (pass || rrx || kind != KIND_LSL || amt <= FULL || (res == '0 && !cout));
    // R8
    asr_fill_chk: assert (pass || rrx || kind != KIND_ASR || amt < FULL
                          || (res == {DATA_W{x[DATA_W-1]}} && cout == x[DATA_W-1]));
    // R5
    rrx_chk: assert (!rrx || pass || (cout == x[0] && res[DATA_W-1] == cin));
  end

endmodule

// File: rtl/opshift_stage.sv
module opshift_stage
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_src,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_value,
  input  logic [SH_W-1:0]   in_imm_amt,
  input  logic [DATA_W-1:0] in_amt_word,
  input  logic [ROT_W-1:0]  in_rot,
  input  logic [IMM_W-1:0]  in_const,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_operand,
  output logic              out_carry
);

  logic [DATA_W-1:0] d_src;
  kind_e             d_kind;
  logic [AMT_W-1:0]  d_amt;
  logic              d_rrx;
  logic              d_pass;
  logic [DATA_W-1:0] s_res;
  logic              s_carry;
  logic              take;

  opshift_decode #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
  ) u_dec (
    .src(in_src), .kind(in_kind), .value(in_value), .imm_amt(in_imm_amt),
    .amt_word(in_amt_word), .rot(in_rot), .cval(in_const),
    .op_src(d_src), .op_kind(d_kind), .op_amt(d_amt), .op_rrx(d_rrx), .op_pass(d_pass)
  );

  opshift_core #(
    .DATA_W(DATA_W), .AMT_W(AMT_W)
  ) u_core (
    .x(d_src), .kind(d_kind), .amt(d_amt), .rrx(d_rrx), .pass(d_pass),
    .cin(in_carry), .res(s_res), .cout(s_carry)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_operand <= '0;
      out_carry   <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_operand <= s_res;
        out_carry   <= s_carry;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R1
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_operand) && $stable(out_carry));
  // R1
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R1
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: tb/tb_opshift_stage.sv
module tb_opshift_stage;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_src = '0;
  logic [1:0]  in_kind = '0;
  logic [31:0] in_value = '0;
  logic [4:0]  in_imm_amt = '0;
  logic [31:0] in_amt_word = '0;
  logic [3:0]  in_rot = '0;
  logic [7:0]  in_const = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_operand;
  logic        out_carry;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  opshift_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_kind(in_kind), .in_value(in_value), .in_imm_amt(in_imm_amt),
    .in_amt_word(in_amt_word), .in_rot(in_rot), .in_const(in_const), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_operand(out_operand),
    .out_carry(out_carry)
  );

  // staged stimulus, applied at the next falling edge
  logic [1:0]  st_src, st_kind;
  logic [31:0] st_value, st_word;
  logic [4:0]  st_imm;
  logic [3:0]  st_rot;
  logic [7:0]  st_const;
  logic        st_carry, st_valid;
  int          ready_pct = 100;

  logic [31:0] q_res[$];
  logic        q_c[$];
  string       q_tag[$];

  logic        stall_prev = 0;
  logic [31:0] held_res;
  logic        held_c;

  // behavioural model, one bit per step
  function automatic void model(input logic [1:0] src, input logic [1:0] kind,
      input logic [31:0] v, input logic [4:0] imm, input logic [31:0] word,
      input logic [3:0] rot, input logic [7:0] k, input logic ci,
      output logic [31:0] r, output logic c);
    int n;
    r = v; c = ci;
    if (src == 2'd3) return;
    if (src == 2'd2) begin
      r = {24'd0, k};
      for (int i = 0; i < 2*rot; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      return;
    end
    if (src == 2'd0) begin
      n = imm;
      if (n == 0 && (kind == 2'd1 || kind == 2'd2)) n = 32;
      if (n == 0 && kind == 2'd3) begin c = v[0]; r = {ci, v[31:1]}; return; end
    end else n = word[7:0];
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'd0: begin c = r[31]; r = r << 1; end
        2'd1: begin c = r[0];  r = r >> 1; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  function automatic string tag_of(input logic [1:0] src, input logic [1:0] kind,
      input logic [4:0] imm, input logic [31:0] word);
    int n;
    if (src == 2'd3) return "R11";
    if (src == 2'd2) return "R10";
    if (src == 2'd0) begin
      if (imm == 0 && kind == 2'd0) return "R3";
      if (imm == 0 && kind == 2'd3) return "R5";
      if (imm == 0) return "R4";
      return "R2";
    end
    n = word[7:0];
    if (n == 0 || word[31:8] != 0) return "R6";
    if (kind <= 2'd1 && n >= 32) return "R7";
    if (kind == 2'd2 && n >= 32) return "R8";
    if (kind == 2'd3 && n % 32 == 0) return "R9";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] ar, input logic [31:0] er,
                       input logic ac, input logic ec);
    tests++;
    if (ar !== er || ac !== ec) begin
      fails++;
      $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b", tag, ar, ac, er, ec);
    end
  endtask

  task automatic cycle(output bit accepted);
    logic [31:0] er;
    logic ec;
    @(negedge clk);
    in_valid = st_valid; in_src = st_src; in_kind = st_kind; in_value = st_value;
    in_imm_amt = st_imm; in_amt_word = st_word; in_rot = st_rot; in_const = st_const;
    in_carry = st_carry;
    out_ready = ($urandom_range(99) < ready_pct);
    #1;
    if (stall_prev) check("R1", out_operand, held_res, out_carry, held_c);
    check("R1", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)}, 1'b0, 1'b0);
    stall_prev = out_valid && !out_ready;
    held_res = out_operand; held_c = out_carry;
    if (out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        tests++; fails++;
        $display("FAIL R1: unexpected output %h expected none", out_operand);
      end else begin
        check(q_tag.pop_front(), out_operand, q_res.pop_front(), out_carry, q_c.pop_front());
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      model(in_src, in_kind, in_value, in_imm_amt, in_amt_word, in_rot, in_const, in_carry, er, ec);
      q_res.push_back(er); q_c.push_back(ec);
      q_tag.push_back(tag_of(in_src, in_kind, in_imm_amt, in_amt_word));
    end
  endtask

  task automatic send(input logic [1:0] src, input logic [1:0] kind, input logic [31:0] v,
      input logic [4:0] imm, input logic [31:0] word, input logic [3:0] rot,
      input logic [7:0] k, input logic ci);
    bit acc;
    st_src = src; st_kind = kind; st_value = v; st_imm = imm; st_word = word;
    st_rot = rot; st_const = k; st_carry = ci; st_valid = 1'b1;
    do cycle(acc); while (!acc);
    st_valid = 1'b0;
  endtask

  initial begin
    bit acc;
    st_valid = 0; st_src = 0; st_kind = 0; st_value = 0; st_imm = 0; st_word = 0;
    st_rot = 0; st_const = 0; st_carry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", {31'd0, out_valid}, 32'd0, 1'b0, 1'b0);

    // R3 / R4 / R5 encoded-zero cases, both carries
    for (int ci = 0; ci < 2; ci++) begin
      for (int k = 0; k < 4; k++) begin
        send(2'd0, 2'(k), 32'h8000_0001, 5'd0, 32'd0, 4'd0, 8'd0, 1'(ci));
        send(2'd0, 2'(k), 32'h7FFF_FFFE, 5'd0, 32'd0, 4'd0, 8'd0, 1'(ci));
      end
    end
    // R2 ordinary amounts
    for (int k = 0; k < 4; k++) begin
      send(2'd0, 2'(k), 32'hA5C3_0F81, 5'd1, 32'd0, 4'd0, 8'd0, 1'b0);
      send(2'd0, 2'(k), 32'hA5C3_0F81, 5'd31, 32'd0, 4'd0, 8'd0, 1'b1);
    end
    // R6..R9 register amounts at the edges, with junk above bit 7
    for (int k = 0; k < 4; k++) begin
      send(2'd1, 2'(k), 32'h8000_0001, 5'd0, 32'h0000_0000, 4'd0, 8'd0, 1'b1);
      send(2'd1, 2'(k), 32'h8000_0001, 5'd0, 32'hFFFF_FF00, 4'd0, 8'd0, 1'b1);
      send(2'd1, 2'(k), 32'h8000_0001, 5'd0, 32'd31, 4'd0, 8'd0, 1'b0);
      send(2'd1, 2'(k), 32'h8000_0001, 5'd0, 32'd32, 4'd0, 8'd0, 1'b0);
      send(2'd1, 2'(k), 32'h8000_0001, 5'd0, 32'd33, 4'd0, 8'd0, 1'b1);
      send(2'd1, 2'(k), 32'h4000_0002, 5'd0, 32'd64, 4'd0, 8'd0, 1'b1);
      send(2'd1, 2'(k), 32'hC000_0003, 5'd0, 32'd255, 4'd0, 8'd0, 1'b1);
      send(2'd1, 2'(k), 32'h1234_5678, 5'd0, 32'h1234_5604, 4'd0, 8'd0, 1'b0);
    end
    // R10 rotated constants, every rotate value
    for (int r = 0; r < 16; r++) begin
      send(2'd2, 2'd0, 32'hFFFF_FFFF, 5'd7, 32'd9, 4'(r), 8'h81, 1'b1);
      send(2'd2, 2'd1, 32'h0, 5'd0, 32'd0, 4'(r), 8'h7E, 1'b0);
    end
    // R11 pass-through
    send(2'd3, 2'd2, 32'hDEAD_BEEF, 5'd3, 32'd5, 4'd2, 8'hFF, 1'b1);
    send(2'd3, 2'd3, 32'h0000_0001, 5'd0, 32'd0, 4'd0, 8'h00, 1'b0);

    // random traffic with back-pressure
    ready_pct = 60;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = $urandom();
      if (i % 3 == 0) w = {24'd0, w[7:0]};
      if (i % 7 == 0) w = {24'd0, 2'd0, w[5:0]};
      send(2'($urandom_range(3)), 2'($urandom_range(3)), $urandom(), 5'($urandom()),
           w, 4'($urandom()), 8'($urandom()), 1'($urandom()));
    end

    // drain
    ready_pct = 100;
    for (int i = 0; i < 10 && q_res.size() != 0; i++) cycle(acc);
    check("R1", 32'(q_res.size()), 32'd0, 1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R1: watchdog expired, outstanding=%0d expected 0", q_res.size());
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule